// File: doc/BRIEF.md
# Post-Link Device Readiness Sequencer

This block sits on the root side of a serial point-to-point link. It decides when configuration traffic to a freshly attached device may start, and it decides whether that device is present at all. It is armed by a one-cycle reset-exit pulse. It then waits for the link-up indication, lets a settling delay run after link training, and places configuration read requests on a simple valid/ready request port. Each completion status is classified as success, retry-status (the device is not ready yet) or error. Any non-success status causes the request to be reissued after a backoff interval.

Two timers with different start events govern the sequence. The settling delay starts at link-up and restarts whenever the link drops. The presence deadline starts at reset exit and keeps running across link drops. If no access succeeds before the deadline, the block declares the device absent. Every interval is derived from the clock frequency parameter, so a bench can use scaled-down counts.

Top module: `cfg_ready_seq`

## Requirements
- R1: While `rst_n` is low, and after release until the first `rst_exit` pulse, `req_valid`, `dev_ready`, `dev_absent`, `ready_pulse` and `absent_pulse` are all 0. Link activity before a reset exit raises no request.
- R2: After a reset exit, `req_valid` is not raised until `link_up` has been high continuously for at least DELAY_CYC = CLK_HZ/1000 × LINK_DELAY_MS cycles. The first request appears two cycles after that interval has elapsed from the first cycle in which `link_up` is seen high.
- R3: Once raised, `req_valid` stays high until a cycle in which `req_ready` is high. That cycle counts as one issued request.
- R4: `cpl_status` codes are 2'b00 success, 2'b01 retry-status, 2'b10 unsupported request and 2'b11 other error. Success leads to the ready state. Each of the other three codes reissues the request BACKOFF_CYCLES + 1 cycles after the completion is sampled.
- R5: If no success arrives within DEADLINE_CYC = CLK_HZ/1000 × DEADLINE_MS cycles of the reset-exit pulse, the block enters the absent state. The deadline runs from the reset exit, independently of when the link came up.
- R6: `ready_pulse` and `absent_pulse` are each high for one cycle, in the first cycle in which `dev_ready` or `dev_absent` respectively is high. `dev_ready` and `dev_absent` are never high together.
- R7: The ready and absent states hold, with no request issued, until the next `rst_exit` pulse. That pulse clears both levels and restarts the sequence. An expiring deadline has no effect once the ready state is reached.
- R8: If `link_up` falls before the ready state, the block drops any outstanding request or backoff and waits for the link again. On the next link-up the full settling delay is applied again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_exit | input | 1 | One-cycle pulse marking the device's reset exit |
| link_up | input | 1 | Link training complete, link active |
| req_valid | output | 1 | Configuration read request pending |
| req_ready | input | 1 | Request port accepts the request |
| cpl_valid | input | 1 | Completion present this cycle |
| cpl_status | input | 2 | Completion status code (see R4) |
| ready_pulse | output | 1 | One-cycle pulse when the device becomes ready |
| absent_pulse | output | 1 | One-cycle pulse when the device is declared absent |
| dev_ready | output | 1 | Level: first configuration access succeeded |
| dev_absent | output | 1 | Level: device declared not present |

## Verification
On every cycle, the assertions check several properties. Each request must be preceded by a long enough unbroken link-up run, and an absent declaration must come only after the full deadline from reset exit. The two status levels must stay exclusive, each pulse must align with the rising edge of its level, the final states must hold, and a stalled request must stay up. Other behaviour only the bench scenarios can show: the exact cycle of each request and decision, the backoff spacing after each of the three non-success codes, a late link-up that loses to the deadline, and the restart of the settling delay after a link drop during backoff.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_WAIT_LINK,
      S_WAIT_DELAY,
      S_ISSUE,
      S_WAIT_CPL,
      S_BACKOFF,
      S_READY,
      S_ABSENT
   } seq_state_e;

   typedef enum logic [1:0] {
      CPL_OK    = 2'b00,
      CPL_RETRY = 2'b01,
      CPL_UNSUP = 2'b10,
      CPL_ERR   = 2'b11
   } cpl_code_e;

endpackage

// File: rtl/cfgseq_timer.sv
module cfgseq_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expired
);
   localparam int W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LIM = W'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("cfgseq_timer: LIMIT must be at least 1");
   end

   logic [W-1:0] cnt;
   logic         active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (start) begin
         cnt    <= '0;
         active <= 1'b1;
      end else if (active && cnt != LIM) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign expired = active && (cnt == LIM);

   // expiry can only follow at least LIMIT cycles after a start, never right after one
   p_fresh_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !expired);

endmodule

// File: rtl/cfgseq_cpl_decode.sv
module cfgseq_cpl_decode
   import cfgseq_pkg::*;
(
   input  logic       valid,
   input  logic [1:0] code,
   output logic       ok,
   output logic       again
);
   // retry-status, unsupported request and other errors all mean "try again later"
   always_comb begin
      ok    = 1'b0;
      again = 1'b0;
      if (valid) begin
         unique case (cpl_code_e'(code))
            CPL_OK:                        ok    = 1'b1;
            CPL_RETRY, CPL_UNSUP, CPL_ERR: again = 1'b1;
            default:                       again = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/cfg_ready_seq.sv
module cfg_ready_seq
   import cfgseq_pkg::*;
#(
   parameter int CLK_HZ         = 100_000_000,
   parameter int LINK_DELAY_MS  = 100,
   parameter int DEADLINE_MS    = 1000,
   parameter int BACKOFF_CYCLES = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rst_exit,
   input  logic       link_up,
   output logic       req_valid,
   input  logic       req_ready,
   input  logic       cpl_valid,
   input  logic [1:0] cpl_status,
   output logic       ready_pulse,
   output logic       absent_pulse,
   output logic       dev_ready,
   output logic       dev_absent
);
   localparam int CYC_PER_MS  = CLK_HZ / 1000;
   localparam int DELAY_CYC   = CYC_PER_MS * LINK_DELAY_MS;
   localparam int DEADLINE_CYC = CYC_PER_MS * DEADLINE_MS;

   if (CLK_HZ < 1000 || (CLK_HZ % 1000) != 0) begin : g_bad_clk
      $error("cfg_ready_seq: CLK_HZ must be a whole number of kHz");
   end
   if (LINK_DELAY_MS < 1) begin : g_bad_delay
      $error("cfg_ready_seq: LINK_DELAY_MS must be at least 1");
   end
   if (DEADLINE_MS <= LINK_DELAY_MS) begin : g_bad_deadline
      $error("cfg_ready_seq: DEADLINE_MS must exceed LINK_DELAY_MS");
   end
   if (BACKOFF_CYCLES < 0) begin : g_bad_backoff
      $error("cfg_ready_seq: BACKOFF_CYCLES must not be negative");
   end

   seq_state_e state, nxt;
   logic dl_start, dly_start, bk_start;
   logic dl_done, dly_done, bk_done;
   logic cpl_ok, cpl_again;
   logic pending;

   cfgseq_timer #(.LIMIT(DEADLINE_CYC)) u_deadline (
      .clk(clk), .rst_n(rst_n), .start(dl_start), .expired(dl_done)
   );

   cfgseq_timer #(.LIMIT(DELAY_CYC)) u_settle (
      .clk(clk), .rst_n(rst_n), .start(dly_start), .expired(dly_done)
   );

   if (BACKOFF_CYCLES == 0) begin : g_no_backoff
      assign bk_done = 1'b1;
      logic unused_bk;
      assign unused_bk = bk_start;
   end else begin : g_backoff
      cfgseq_timer #(.LIMIT(BACKOFF_CYCLES)) u_backoff (
         .clk(clk), .rst_n(rst_n), .start(bk_start), .expired(bk_done)
      );
   end

   cfgseq_cpl_decode u_dec (
      .valid(cpl_valid), .code(cpl_status), .ok(cpl_ok), .again(cpl_again)
   );

   assign pending = (state == S_WAIT_LINK) || (state == S_WAIT_DELAY) ||
                    (state == S_ISSUE) || (state == S_WAIT_CPL) ||
                    (state == S_BACKOFF);

   always_comb begin
      nxt       = state;
      dl_start  = 1'b0;
      dly_start = 1'b0;
      bk_start  = 1'b0;
      if (rst_exit) begin
         nxt      = S_WAIT_LINK;
         dl_start = 1'b1;
      end else if (pending && dl_done) begin
         nxt = S_ABSENT;
      end else if (pending && !link_up) begin
         nxt = S_WAIT_LINK;
      end else begin
         unique case (state)
            S_WAIT_LINK: begin
               nxt       = S_WAIT_DELAY;
               dly_start = 1'b1;
            end
            S_WAIT_DELAY: if (dly_done) nxt = S_ISSUE;
            S_ISSUE:      if (req_ready) nxt = S_WAIT_CPL;
            S_WAIT_CPL: begin
               if (cpl_ok) begin
                  nxt = S_READY;
               end else if (cpl_again) begin
                  nxt      = S_BACKOFF;
                  bk_start = 1'b1;
               end
            end
            S_BACKOFF:    if (bk_done) nxt = S_ISSUE;
            default:      nxt = state;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= S_IDLE;
         ready_pulse  <= 1'b0;
         absent_pulse <= 1'b0;
      end else begin
         state        <= nxt;
         ready_pulse  <= (nxt == S_READY) && (state != S_READY);
         absent_pulse <= (nxt == S_ABSENT) && (state != S_ABSENT);
      end
   end

   assign req_valid  = (state == S_ISSUE);
   assign dev_ready  = (state == S_READY);
   assign dev_absent = (state == S_ABSENT);

   // ---------------- checking counters and assertions ----------------
   localparam int LW = $clog2(DELAY_CYC + 1);
   localparam int DW = $clog2(DEADLINE_CYC + 1);
   localparam logic [LW-1:0] L_SAT = LW'(DELAY_CYC);
   localparam logic [DW-1:0] D_SAT = DW'(DEADLINE_CYC);

   logic [LW-1:0] link_run;
   logic [DW-1:0] since_exit;
   logic          exit_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_run   <= '0;
         since_exit <= '0;
         exit_seen  <= 1'b0;
      end else begin
         if (!link_up)            link_run <= '0;
         else if (link_run != L_SAT) link_run <= link_run + 1'b1;
         if (rst_exit) begin
            since_exit <= '0;
            exit_seen  <= 1'b1;
         end else if (exit_seen && since_exit != D_SAT) begin
            since_exit <= since_exit + 1'b1;
         end
      end
   end

   p_req_after_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (link_run >= L_SAT));

   p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && link_up && !rst_exit && !dl_done) |=> req_valid);

   p_retry_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid == 1'b0 && cpl_valid && cpl_status != 2'b00 && !dev_ready && !rst_exit)
      |=> !dev_ready);

   p_absent_after_deadline_r5: assert property (@(posedge clk) disable iff (!rst_n)
      absent_pulse |-> (exit_seen && since_exit >= D_SAT));

   p_levels_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_ready && dev_absent));

   p_ready_pulse_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ready_pulse |-> (dev_ready && !$past(dev_ready)));

   p_absent_pulse_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      absent_pulse |-> (dev_absent && !$past(dev_absent)));

   p_ready_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ready && !rst_exit) |=> dev_ready);

   p_absent_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_absent && !rst_exit) |=> dev_absent);

   p_quiet_when_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ready || dev_absent) |-> !req_valid);

   p_drop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up && !rst_exit && !dev_ready) |=> !req_valid);

endmodule

// File: tb/sim_cfg_ready_seq.sv
module sim_cfg_ready_seq;
   localparam int L  = 100;   // settle delay in cycles (1 cycle per ms)
   localparam int D  = 1000;  // deadline in cycles
   localparam int BK = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rst_exit = 1'b0;
   logic link_up = 1'b0;
   logic req_ready = 1'b1;
   logic cpl_valid = 1'b0;
   logic [1:0] cpl_status = 2'b00;
   logic req_valid, ready_pulse, absent_pulse, dev_ready, dev_absent;

   cfg_ready_seq #(
      .CLK_HZ(1000), .LINK_DELAY_MS(100), .DEADLINE_MS(1000), .BACKOFF_CYCLES(BK)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .rst_exit(rst_exit), .link_up(link_up),
      .req_valid(req_valid), .req_ready(req_ready), .cpl_valid(cpl_valid),
      .cpl_status(cpl_status), .ready_pulse(ready_pulse), .absent_pulse(absent_pulse),
      .dev_ready(dev_ready), .dev_absent(dev_absent)
   );

   always #10 clk = ~clk;   // 50 MHz

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int errors = 0;
   int checks = 0;

   // scoreboard: kind 0 = request handshake, 1 = ready pulse, 2 = absent pulse
   int    q_kind[$];
   int    q_lo[$];
   int    q_hi[$];
   string q_tag[$];
   logic [1:0] resp_q[$];
   logic [1:0] resp_default = 2'b00;
   bit ignore_req = 1'b0;
   int req_seen = 0;
   int pend = -1;

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic check_eq(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic push_exp(int kind, int at, string tag);
      q_kind.push_back(kind);
      q_lo.push_back(at - 1);
      q_hi.push_back(at + 1);
      q_tag.push_back(tag);
   endtask

   task automatic note(int kind);
      int k, lo, hi;
      string tg;
      if (kind == 0 && ignore_req) begin
         req_seen++;
         return;
      end
      checks++;
      if (q_kind.size() == 0) begin
         errors++;
         $display("FAIL %s unexpected event kind at cycle %0d: actual=%0d expected=none",
                  (kind == 0) ? "R2" : (kind == 1) ? "R4" : "R5", cyc, kind);
         return;
      end
      k  = q_kind.pop_front();
      lo = q_lo.pop_front();
      hi = q_hi.pop_front();
      tg = q_tag.pop_front();
      if (k != kind || cyc < lo || cyc > hi) begin
         errors++;
         $display("FAIL %s event: actual kind=%0d cycle=%0d expected kind=%0d cycle=%0d..%0d",
                  tg, kind, cyc, k, lo, hi);
      end
   endtask

   // monitor: observes the values of the cycle that is ending
   always @(posedge clk) begin
      if (rst_n) begin
         if (req_valid && req_ready) begin
            note(0);
            pend = cyc + 3;
         end
         if (ready_pulse)  note(1);
         if (absent_pulse) note(2);
      end
   end

   // completion responder
   always @(negedge clk) begin
      cpl_valid = 1'b0;
      if (pend >= 0 && cyc == pend) begin
         cpl_valid = 1'b1;
         if (resp_q.size() > 0) cpl_status = resp_q.pop_front();
         else                   cpl_status = resp_default;
         pend = -1;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_to(int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic exit_pulse(output int r);
      @(negedge clk);
      r = cyc;
      rst_exit = 1'b1;
      @(negedge clk);
      rst_exit = 1'b0;
   endtask

   initial begin
      int r, a, a2, hs, h1, h2, h3;
      tick(3);
      // R1: outputs low under reset
      check_eq("R1", "req_valid in reset", int'(req_valid), 0);
      check_eq("R1", "dev_ready in reset", int'(dev_ready), 0);
      check_eq("R1", "dev_absent in reset", int'(dev_absent), 0);
      rst_n = 1'b1;
      // R1: link activity without a reset exit raises nothing
      link_up = 1'b1;
      tick(200);
      check_eq("R1", "req_valid before reset exit", int'(req_valid), 0);
      check_eq("R1", "pulses before reset exit", int'(ready_pulse | absent_pulse), 0);
      link_up = 1'b0;
      tick(2);

      // Scenario C, R5: link comes up too late, deadline counted from reset exit
      exit_pulse(r);
      wait_to(r + 950);
      link_up = 1'b1;
      push_exp(2, r + 2 + D, "R5");
      wait_to(r + D + 60);
      check_eq("R5", "dev_absent after deadline", int'(dev_absent), 1);
      check_eq("R6", "dev_ready while absent", int'(dev_ready), 0);
      check_eq("R7", "req_valid while absent", int'(req_valid), 0);
      link_up = 1'b0;
      tick(2);

      // Scenario A, R2/R4: retry-status, then unsupported, then success
      resp_q = '{2'b01, 2'b10, 2'b00};
      exit_pulse(r);
      check_eq("R7", "dev_absent cleared by reset exit", int'(dev_absent), 0);
      wait_to(r + 5);
      link_up = 1'b1;
      a  = cyc;
      h1 = a + 2 + L;
      h2 = h1 + 5 + BK;
      h3 = h2 + 5 + BK;
      push_exp(0, h1, "R2");
      push_exp(0, h2, "R4");
      push_exp(0, h3, "R4");
      push_exp(1, h3 + 4, "R4");
      wait_to(h3 + 10);
      check_eq("R4", "dev_ready after success", int'(dev_ready), 1);
      check_eq("R6", "dev_absent with ready", int'(dev_absent), 0);
      wait_to(r + D + 20);
      check_eq("R7", "dev_ready holds past deadline", int'(dev_ready), 1);
      check_eq("R7", "dev_absent past deadline when ready", int'(dev_absent), 0);
      link_up = 1'b0;
      tick(2);

      // Scenario B, R3/R8: stalled request, then link drop during backoff
      req_ready = 1'b0;
      resp_q = '{2'b01, 2'b00};
      exit_pulse(r);
      wait_to(r + 3);
      link_up = 1'b1;
      a  = cyc;
      h1 = a + 2 + L;
      hs = h1 + 3;
      push_exp(0, hs, "R3");
      wait_to(h1);
      check_eq("R3", "req_valid raised while port stalls", int'(req_valid), 1);
      wait_to(hs);
      check_eq("R3", "req_valid held through stall", int'(req_valid), 1);
      req_ready = 1'b1;
      wait_to(hs + 6);
      link_up = 1'b0;
      wait_to(hs + 8);
      check_eq("R8", "req_valid after link drop", int'(req_valid), 0);
      check_eq("R8", "dev_ready after link drop", int'(dev_ready), 0);
      wait_to(hs + 10);
      link_up = 1'b1;
      a2 = cyc;
      h2 = a2 + 2 + L;
      push_exp(0, h2, "R8");
      push_exp(1, h2 + 4, "R4");
      wait_to(h2 + 10);
      check_eq("R8", "dev_ready after relink", int'(dev_ready), 1);
      link_up = 1'b0;
      tick(2);

      // Scenario D, R4/R5: device keeps answering with other-error status
      ignore_req = 1'b1;
      req_seen = 0;
      resp_default = 2'b11;
      exit_pulse(r);
      check_eq("R7", "dev_ready cleared by reset exit", int'(dev_ready), 0);
      wait_to(r + 3);
      link_up = 1'b1;
      push_exp(2, r + 2 + D, "R5");
      wait_to(r + D + 20);
      checks++;
      if (req_seen < 2) begin
         errors++;
         $display("FAIL R4 reissues after error status: actual=%0d expected>=2", req_seen);
      end
      check_eq("R5", "dev_absent after persistent errors", int'(dev_absent), 1);
      ignore_req = 1'b0;
      link_up = 1'b0;
      tick(20);

      check_eq("R2", "expected events left unseen", q_kind.size(), 0);
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

endmodule